// File: doc/BRIEF.md
# Machine Timer and Counter Offset Unit

This block keeps a 64-bit timer-compare value and raises a timer-pending flag once the free-running real-time count reaches it. The real-time count and the retired-instruction count arrive as inputs; the block never modifies them. Software sees user-level time, cycle and instret views. Each view is the hardware count plus a stored offset, so a write to a view changes only the offset.

Access is through a register-style port. There are read and write strobes, a 4-bit select, write data of width XLEN (32 or 64) and combinational read data. A read returns data in the same cycle it is strobed, and a write takes effect at the next clock edge. With XLEN of 32, every 64-bit quantity is reached through separate low and high selects. Writing a low half of a user view replaces only the low 32 bits of its offset. Writing a high half replaces only the upper 32 bits. With XLEN of 64, the high-half user views and the compare high half do not exist.

Top module: `rt_timer_csr`

## Requirements
- R1: After reset, timer_pend is 0, the compare value is all ones, and both offsets are zero, so user views read the raw counts.
- R2: timer_pend is set at the first clock edge at which rt_count is greater than or equal to the compare value. It then stays set (sticky) until the compare is written, even if rt_count falls back below the compare.
- R3: A write to either compare select (0 = low, 1 = high) clears timer_pend at that edge and loads the new value. If rt_count is at or above the new value, timer_pend sets again at the following edge.
- R4: With XLEN 32, select 0 reads and writes compare bits 31:0 and select 1 reads and writes bits 63:32; each write leaves the other half unchanged. With XLEN 64, select 0 holds all 64 bits.
- R5: Select 2 reads rt_count (low XLEN bits) and select 3 reads rt_count bits 63:32 zero-extended. Writes to either select are ignored and leave the offsets and the compare unchanged.
- R6: Select 4 reads (rt_count + time offset) low XLEN bits. Writing V there sets the offset to V - rt_count. With XLEN 32, only offset bits 31:0 are replaced, by (V - rt_count[31:0]) mod 2^32.
- R7: With XLEN 32, select 5 reads bits 63:32 of (rt_count + time offset). Writing V there sets offset bits 63:32 to V - rt_count[63:32] - (rt_count[31:0] != 0), modulo 2^32, and keeps offset bits 31:0.
- R8: Selects 6 (cycle) and 8 (instret) are one view of retired_count plus a single shared offset. Selects 7 and 9 are the high halves of that view. Writes to any of the four follow the rules of R6 and R7, using retired_count, and do not touch the time offset.
- R9: With XLEN 64, an access to select 1, 5, 7 or 9 raises bad_access in that cycle. Such a read returns 0, and such a write changes nothing.
- R10: Selects 10 to 15 are unmapped. An access to one raises bad_access, reads return 0, and writes change no state. bad_access is 0 for mapped accesses and when no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_count | input | 64 | Free-running real-time count |
| retired_count | input | 64 | Retired-instruction count |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sel | input | 4 | Register select |
| wdata | input | XLEN | Write data |
| rdata | output | XLEN | Read data, valid in the strobe cycle |
| timer_pend | output | 1 | Timer-pending flag |
| bad_access | output | 1 | Access to an unmapped or unavailable select |

## Verification
The compare is tried with the count below, equal to and above it, with a rewrite to a value still exceeded, and with the count dropping back after a hit. These cases separate a live comparison from a sticky flag and from the clear-on-write. Offsets are tested with counts that carry from the low word into the high word, so a split low/high update that borrows wrongly or overwrites the other half reads back a different value. Cycle and instret writes are interleaved with time reads to show the shared offset and the separate time offset. Both XLEN settings are run side by side, so the high selects that only 32-bit mode has are seen as legal in one and flagged in the other.

// File: rtl/rt_timer_pkg.sv
package rt_timer_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMP_LO   = 4'd0,
    SEL_CMP_HI   = 4'd1,
    SEL_RT_LO    = 4'd2,
    SEL_RT_HI    = 4'd3,
    SEL_UTIME_LO = 4'd4,
    SEL_UTIME_HI = 4'd5,
    SEL_UCYC_LO  = 4'd6,
    SEL_UCYC_HI  = 4'd7,
    SEL_UINST_LO = 4'd8,
    SEL_UINST_HI = 4'd9
  } rt_sel_e;

  typedef struct packed {
    logic cmp_lo;
    logic cmp_hi;
    logic rt_lo;
    logic rt_hi;
    logic tm_lo;
    logic tm_hi;
    logic cy_lo;
    logic cy_hi;
  } rt_hit_t;

  // full-width difference between a requested view value and the count
  function automatic logic [CNT_W-1:0] offset_from_low(input logic [CNT_W-1:0] val,
                                                       input logic [CNT_W-1:0] cnt);
    return val - cnt;
  endfunction

  // upper half of ((val << HALF_W) - cnt)
  function automatic logic [HALF_W-1:0] offset_from_high(input logic [HALF_W-1:0] val,
                                                         input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] shifted;
    logic [CNT_W-1:0] diff;
    shifted = {val, {HALF_W{1'b0}}};
    diff    = shifted - cnt;
    return diff[CNT_W-1:HALF_W];
  endfunction

  function automatic logic [CNT_W-1:0] view_of(input logic [CNT_W-1:0] cnt,
                                               input logic [CNT_W-1:0] off);
    return cnt + off;
  endfunction
endpackage

// File: rtl/rt_sel_decode.sv
module rt_sel_decode
  import rt_timer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  output rt_hit_t          hit,
  output logic             illegal
);
  localparam bit WIDE = (XLEN == 64);

  logic mapped;
  logic narrow_only;
  logic blocked;

  always_comb begin
    hit         = '0;
    mapped      = 1'b1;
    narrow_only = 1'b0;
    case (sel)
      SEL_CMP_LO:   hit.cmp_lo = 1'b1;
      SEL_CMP_HI:   begin hit.cmp_hi = 1'b1; narrow_only = 1'b1; end
      SEL_RT_LO:    hit.rt_lo = 1'b1;
      SEL_RT_HI:    hit.rt_hi = 1'b1;
      SEL_UTIME_LO: hit.tm_lo = 1'b1;
      SEL_UTIME_HI: begin hit.tm_hi = 1'b1; narrow_only = 1'b1; end
      SEL_UCYC_LO,
      SEL_UINST_LO: hit.cy_lo = 1'b1;
      SEL_UCYC_HI,
      SEL_UINST_HI: begin hit.cy_hi = 1'b1; narrow_only = 1'b1; end
      default:      mapped = 1'b0;
    endcase
    blocked = !mapped || (WIDE && narrow_only);
    if (blocked) hit = '0;
    illegal = (rd_en | wr_en) & blocked;
  end
endmodule

// File: rtl/rt_compare_unit.sv
module rt_compare_unit
  import rt_timer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rt_count,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic             pend_q
);
  logic cmp_write;
  logic cmp_reached;

  assign cmp_write   = wr_lo | wr_hi;
  assign cmp_reached = (rt_count >= cmp_q);

  generate
    if (XLEN == CNT_W) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cmp_q <= '1;
        else if (wr_lo) cmp_q <= CNT_W'(wdata);
      end
    end else begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_q <= '1;
        end else begin
          if (wr_lo) cmp_q[HALF_W-1:0]     <= wdata[HALF_W-1:0];
          if (wr_hi) cmp_q[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (cmp_write)   pend_q <= 1'b0;
    else if (cmp_reached) pend_q <= 1'b1;
  end

  // R2
  reach_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_reached && !cmp_write) |=> pend_q);

  // R2
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cmp_write) |=> pend_q);

  // R3
  write_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_write |=> !pend_q);
endmodule

// File: rtl/rt_offset_reg.sv
module rt_offset_reg
  import rt_timer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] off_q
);
  logic [CNT_W-1:0]  lo_diff;
  logic [HALF_W-1:0] hi_diff;

  assign lo_diff = offset_from_low(CNT_W'(wdata), count);
  assign hi_diff = offset_from_high(wdata[HALF_W-1:0], count);

  generate
    if (XLEN == CNT_W) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     off_q <= '0;
        else if (wr_lo) off_q <= lo_diff;
      end
    end else begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          off_q <= '0;
        end else begin
          if (wr_lo) off_q[HALF_W-1:0]     <= lo_diff[HALF_W-1:0];
          if (wr_hi) off_q[CNT_W-1:HALF_W] <= hi_diff;
        end
      end

      // R6
      lo_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (off_q[CNT_W-1:HALF_W] == $past(off_q[CNT_W-1:HALF_W])));

      // R7
      hi_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(off_q[HALF_W-1:0]));
    end
  endgenerate
endmodule

// File: rtl/rt_timer_csr.sv
module rt_timer_csr
  import rt_timer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      rt_count,
  input  logic [63:0]      retired_count,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [3:0]       sel,
  input  logic [XLEN-1:0]  wdata,
  output logic [XLEN-1:0]  rdata,
  output logic             timer_pend,
  output logic             bad_access
);
  rt_hit_t          hit;
  logic             illegal;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] time_off;
  logic [CNT_W-1:0] cyc_off;
  logic [CNT_W-1:0] time_view;
  logic [CNT_W-1:0] cyc_view;
  logic             raw_time_write;

  rt_sel_decode #(.XLEN(XLEN)) u_decode (
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .sel     (sel),
    .hit     (hit),
    .illegal (illegal)
  );

  rt_compare_unit #(.XLEN(XLEN)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .rt_count (rt_count),
    .wr_lo    (wr_en & hit.cmp_lo),
    .wr_hi    (wr_en & hit.cmp_hi),
    .wdata    (wdata),
    .cmp_q    (cmp_q),
    .pend_q   (timer_pend)
  );

  rt_offset_reg #(.XLEN(XLEN)) u_time_off (
    .clk   (clk),
    .rst_n (rst_n),
    .count (rt_count),
    .wr_lo (wr_en & hit.tm_lo),
    .wr_hi (wr_en & hit.tm_hi),
    .wdata (wdata),
    .off_q (time_off)
  );

  rt_offset_reg #(.XLEN(XLEN)) u_cyc_off (
    .clk   (clk),
    .rst_n (rst_n),
    .count (retired_count),
    .wr_lo (wr_en & hit.cy_lo),
    .wr_hi (wr_en & hit.cy_hi),
    .wdata (wdata),
    .off_q (cyc_off)
  );

  assign time_view      = view_of(rt_count, time_off);
  assign cyc_view       = view_of(retired_count, cyc_off);
  assign raw_time_write = wr_en & (hit.rt_lo | hit.rt_hi);
  assign bad_access     = illegal;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (1'b1)
        hit.cmp_lo: rdata = XLEN'(cmp_q);
        hit.cmp_hi: rdata = XLEN'(cmp_q[CNT_W-1:HALF_W]);
        hit.rt_lo:  rdata = XLEN'(rt_count);
        hit.rt_hi:  rdata = XLEN'(rt_count[CNT_W-1:HALF_W]);
        hit.tm_lo:  rdata = XLEN'(time_view);
        hit.tm_hi:  rdata = XLEN'(time_view[CNT_W-1:HALF_W]);
        hit.cy_lo:  rdata = XLEN'(cyc_view);
        hit.cy_hi:  rdata = XLEN'(cyc_view[CNT_W-1:HALF_W]);
        default:    rdata = '0;
      endcase
    end
  end

  // R5
  raw_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_time_write |=> ($stable(time_off) && $stable(cyc_off) && $stable(cmp_q)));

  // R10
  bad_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (rdata == '0));

  // R10
  bad_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_access) |=> ($stable(time_off) && $stable(cyc_off) && $stable(cmp_q)));
endmodule

// File: tb/test_rt_timer_csr.sv
module test_rt_timer_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rt_cnt = 64'd100;
  logic [63:0] ret_cnt = 64'd0;

  logic        a_rd = 0, a_wr = 0;
  logic [3:0]  a_sel = 0;
  logic [31:0] a_wd = 0;
  logic [31:0] a_rdata;
  logic        a_pend, a_bad;

  logic        b_rd = 0, b_wr = 0;
  logic [3:0]  b_sel = 0;
  logic [63:0] b_wd = 0;
  logic [63:0] b_rdata;
  logic        b_pend, b_bad;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side offset models
  logic [63:0] t_a = 0, c_a = 0, t_b = 0, c_b = 0;
  logic        last_bad;

  always #4 clk = ~clk;

  rt_timer_csr #(.XLEN(32)) i_rt_timer_csr (
    .clk(clk), .rst_n(rst_n), .rt_count(rt_cnt), .retired_count(ret_cnt),
    .rd_en(a_rd), .wr_en(a_wr), .sel(a_sel), .wdata(a_wd),
    .rdata(a_rdata), .timer_pend(a_pend), .bad_access(a_bad));

  rt_timer_csr #(.XLEN(64)) i_rt_timer_csr_w (
    .clk(clk), .rst_n(rst_n), .rt_count(rt_cnt), .retired_count(ret_cnt),
    .rd_en(b_rd), .wr_en(b_wr), .sel(b_sel), .wdata(b_wd),
    .rdata(b_rdata), .timer_pend(b_pend), .bad_access(b_bad));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // low-half offset model: only the low word moves, by subtraction mod 2^32
  function automatic logic [63:0] m_lo32(input logic [63:0] off, input logic [31:0] v,
                                         input logic [63:0] cnt);
    logic [31:0] lo;
    lo = v - cnt[31:0];
    return {off[63:32], lo};
  endfunction

  // high-half model written as a borrow from the low word
  function automatic logic [63:0] m_hi32(input logic [63:0] off, input logic [31:0] v,
                                         input logic [63:0] cnt);
    logic [31:0] hi;
    hi = v - cnt[63:32] - ((cnt[31:0] != 32'd0) ? 32'd1 : 32'd0);
    return {hi, off[31:0]};
  endfunction

  task automatic a_write(input logic [3:0] s, input logic [31:0] v);
    @(negedge clk);
    a_wr = 1; a_sel = s; a_wd = v;
    #1 last_bad = a_bad;
    @(negedge clk);
    a_wr = 0;
  endtask

  task automatic b_write(input logic [3:0] s, input logic [63:0] v);
    @(negedge clk);
    b_wr = 1; b_sel = s; b_wd = v;
    #1 last_bad = b_bad;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic a_read(input logic [3:0] s, output logic [31:0] d, output logic bad);
    a_rd = 1; a_sel = s;
    #1 d = a_rdata; bad = a_bad;
    a_rd = 0;
  endtask

  task automatic b_read(input logic [3:0] s, output logic [63:0] d, output logic bad);
    b_rd = 1; b_sel = s;
    #1 d = b_rdata; bad = b_bad;
    b_rd = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] q; logic bd;
    check("R1 pend32", a_pend, 0);
    check("R1 pend64", b_pend, 0);
    a_read(4'd0, d, bd); check("R1 cmp lo", d, 32'hFFFF_FFFF);
    a_read(4'd1, d, bd); check("R1 cmp hi", d, 32'hFFFF_FFFF);
    a_read(4'd4, d, bd); check("R1 utime raw", d, rt_cnt[31:0]);
    b_read(4'd0, q, bd); check("R1 cmp64", q, 64'hFFFF_FFFF_FFFF_FFFF);
    b_read(4'd8, q, bd); check("R1 instret raw", q, ret_cnt);
  endtask

  task automatic t_timer32;
    logic [31:0] d; logic bd;
    a_write(4'd0, 32'd200);
    a_write(4'd1, 32'd0);
    check("R2 below cmp", a_pend, 0);
    a_read(4'd0, d, bd); check("R4 cmp lo", d, 200);
    a_read(4'd1, d, bd); check("R4 cmp hi", d, 0);
    rt_cnt = 64'd200;
    @(negedge clk); check("R2 equal sets", a_pend, 1);
    a_write(4'd0, 32'd300);
    check("R3 write clears", a_pend, 0);
    @(negedge clk); check("R3 new cmp not reached", a_pend, 0);
    a_read(4'd0, d, bd); check("R4 cmp lo reload", d, 300);
    a_read(4'd1, d, bd); check("R4 cmp hi kept", d, 0);
    rt_cnt = 64'd500;
    @(negedge clk); check("R2 above sets", a_pend, 1);
    a_write(4'd0, 32'd450);
    check("R3 clear on exceeded cmp", a_pend, 0);
    @(negedge clk); check("R3 resets after clear", a_pend, 1);
    rt_cnt = 64'd10;
    @(negedge clk); @(negedge clk); check("R2 sticky", a_pend, 1);
  endtask

  task automatic t_rawtime;
    logic [31:0] d; logic [63:0] q; logic bd;
    rt_cnt = 64'h0000_00AB_1234_5678;
    a_read(4'd2, d, bd); check("R5 raw lo", d, 32'h1234_5678);
    a_read(4'd3, d, bd); check("R5 raw hi", d, 32'h0000_00AB);
    a_write(4'd2, 32'hDEAD_0000);
    a_write(4'd3, 32'hBEEF_0000);
    a_read(4'd2, d, bd); check("R5 raw lo after write", d, 32'h1234_5678);
    a_read(4'd4, d, bd); check("R5 utime offset untouched", d, 32'h1234_5678);
    a_read(4'd0, d, bd); check("R5 cmp untouched", d, 450);
    b_read(4'd2, q, bd); check("R5 raw64", q, rt_cnt);
    b_read(4'd3, q, bd); check("R5 raw hi64", q, 64'hAB);
    check("R5 hi64 legal", bd, 0);
  endtask

  task automatic t_utime32;
    logic [31:0] d; logic [63:0] v; logic bd;
    rt_cnt = 64'h0000_0001_0000_0010;
    a_write(4'd4, 32'd5); t_a = m_lo32(t_a, 32'd5, rt_cnt);
    v = rt_cnt + t_a;
    a_read(4'd4, d, bd); check("R6 utime lo", d, 32'd5);
    a_read(4'd5, d, bd); check("R6 utime hi model", d, v[63:32]);
    a_write(4'd5, 32'd7); t_a = m_hi32(t_a, 32'd7, rt_cnt);
    a_read(4'd5, d, bd); check("R7 utime hi", d, 32'd7);
    a_read(4'd4, d, bd); check("R7 lo kept", d, 32'd5);
    rt_cnt = rt_cnt + 64'd3;
    a_read(4'd4, d, bd); check("R6 advance", d, 32'd8);
    rt_cnt = 64'h0000_0003_FFFF_FFF0;
    a_write(4'd5, 32'd9); t_a = m_hi32(t_a, 32'd9, rt_cnt);
    v = rt_cnt + t_a;
    a_read(4'd5, d, bd); check("R7 borrow hi", d, v[63:32]);
    a_read(4'd4, d, bd); check("R7 borrow lo", d, v[31:0]);
  endtask

  task automatic t_cycles32;
    logic [31:0] d; logic [63:0] v; logic bd;
    ret_cnt = 64'd1000;
    a_write(4'd6, 32'd50); c_a = m_lo32(c_a, 32'd50, ret_cnt);
    a_read(4'd8, d, bd); check("R8 instret shares", d, 32'd50);
    a_read(4'd6, d, bd); check("R8 cycle lo", d, 32'd50);
    ret_cnt = 64'd1010;
    a_read(4'd8, d, bd); check("R8 instret advance", d, 32'd60);
    a_write(4'd9, 32'd3); c_a = m_hi32(c_a, 32'd3, ret_cnt);
    v = ret_cnt + c_a;
    a_read(4'd7, d, bd); check("R8 cycle hi", d, v[63:32]);
    check("R8 cycle hi value", v[63:32], 3);
    v = rt_cnt + t_a;
    a_read(4'd4, d, bd); check("R8 time offset separate", d, v[31:0]);
  endtask

  task automatic t_wide64;
    logic [63:0] q; logic bd;
    rt_cnt = 64'h0000_0002_0000_0000;
    b_write(4'd4, 64'h1234_5678_9ABC_DEF0); t_b = 64'h1234_5678_9ABC_DEF0 - rt_cnt;
    b_read(4'd4, q, bd); check("R6 utime64", q, 64'h1234_5678_9ABC_DEF0);
    b_read(4'd5, q, bd); check("R9 hi read flagged", bd, 1);
    check("R9 hi read zero", q, 0);
    b_write(4'd5, 64'h55);
    check("R9 hi write flagged", last_bad, 1);
    b_read(4'd4, q, bd); check("R9 hi write ignored", q, rt_cnt + t_b);
    b_read(4'd1, q, bd); check("R9 cmp hi flagged", bd, 1);
    b_read(4'd9, q, bd); check("R9 instret hi flagged", bd, 1);
    b_write(4'd0, 64'h0000_0002_0000_0005);
    check("R3 cmp64 clears", b_pend, 0);
    @(negedge clk); check("R2 cmp64 below", b_pend, 0);
    b_read(4'd0, q, bd); check("R4 cmp64", q, 64'h0000_0002_0000_0005);
    rt_cnt = 64'h0000_0002_0000_0005;
    @(negedge clk); check("R2 cmp64 hit", b_pend, 1);
    ret_cnt = 64'd123;
    b_write(4'd6, 64'd77); c_b = 64'd77 - ret_cnt;
    b_read(4'd8, q, bd); check("R8 instret64", q, ret_cnt + c_b);
  endtask

  task automatic t_illegal;
    logic [31:0] d; logic [63:0] q, v; logic bd;
    a_read(4'd12, d, bd); check("R10 unmapped flag", bd, 1);
    check("R10 unmapped zero", d, 0);
    a_write(4'd13, 32'hFFFF_FFFF);
    check("R10 unmapped write flag", last_bad, 1);
    v = rt_cnt + t_a;
    a_read(4'd4, d, bd); check("R10 write inert time", d, v[31:0]);
    check("R10 legal no flag", bd, 0);
    a_read(4'd0, d, bd); check("R10 write inert cmp", d, 450);
    b_read(4'd15, q, bd); check("R10 unmapped64", bd, 1);
    #1 check("R10 idle no flag", a_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timer32;
    t_rawtime;
    t_utime32;
    t_cycles32;
    t_wide64;
    t_illegal;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule